// File: doc/BRIEF.md
# Delay Line Timing Guard Monitor

This block sits next to a three-bit programmable delay line and polices how the surrounding logic drives it. On every clock tick it samples the step select, the active-high disable, the input fed into the line and the line's true output. It measures the spacing between those events in clock ticks and flags any use that could make the line's output unreliable. The line itself is not modelled or corrected.

Six rules are watched. The select must settle before an input edge. The line must be re-enabled before an input edge. The select must settle before the disable changes. A raised select may change only once the line has drained its last output edge. After a disable, the line must be left quiet until it clears. Input pulses must have a minimum width. Each rule owns a sticky flag bit. A separate live status reports whether a window in which spurious output is possible is still open.

The step increment, the setup spans and the pulse-width fraction are parameters, all counted in clock ticks. The full programmable span is (2^AW − 1) × increment. With the default AW = 3 that is 7 × increment. The block has no data stream, so all its pins are plain control and status levels.

Top module: `dly_guard_mon`

## Requirements
- R1: An input edge sampled fewer than AIS_TICKS samples after the last select change sets flag bit 0.
- R2: An input edge sampled fewer than ENIS_TICKS samples after the disable last fell sets flag bit 1.
- R3: A change of the disable sampled fewer than AENS_TICKS samples after the last select change sets flag bit 2.
- R4: When the select changes from old to new, the required wait is max(new − old, 0) × INC_TICKS. If the change comes fewer samples than that after the last output edge, flag bit 3 is set. Lowering the select, or keeping it equal, never sets bit 3.
- R5: A rise of the disable at sample k with select value a opens a quiet window of a × INC_TICKS samples (k onward). In every sample of that window the disable must be high and the input low, or flag bit 4 is set. A select of 0 opens no window.
- R6: Two consecutive input edges fewer than PW_MIN samples apart set flag bit 5. PW_MIN is ceil(7 × INC_TICKS × PW_PCT / 100) for AW = 3.
- R7: Reset clears all flags and the spurious status. The first sample after reset is only a reference and never counts as an edge. Flags stay set until reset.
- R8: After a bit 3 violation with required wait W and distance d, spur_open is high for exactly W − d cycles. After a bit 4 violation at offset v into a window of length L, spur_open is high for max(L − 1 − v, 0) cycles.
- R9: A stimulus sequence that respects every spacing leaves all flags and spur_open low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; one tick is the time unit |
| rst_n | input | 1 | Active-low synchronous reset |
| dl_sel | input | AW | Step select driven to the delay line |
| dl_dis | input | 1 | Active-high disable driven to the delay line |
| dl_in | input | 1 | Signal entering the delay line |
| dl_out | input | 1 | True (non-inverted) output of the delay line |
| viol_flags | output | 6 | Sticky rule flags, bit order as in R1 to R6 |
| spur_open | output | 1 | High while spurious output is still possible |

## Verification
The retune rule is swept over all 64 old/new select pairs, at every output-to-change distance from 0 to 15. This separates raising from lowering and places the boundary at exactly (new − old) × INC_TICKS. It also measures the spurious window length for each pair. The quiet-window rule is swept over all select values, with the enable coming back at each offset. An extra case pulses the input while the line is disabled, which separates window length zero from a real window. The three setup rules and the pulse width are swept across their thresholds with single edges, so each can only set its own bit. A long clean sequence checks that nothing fires when all spacings are legal.

// File: rtl/dlg_pkg.sv
package dlg_pkg;
  localparam int unsigned N_RULE = 6;

  // flag bit positions, visible at the top-level port
  localparam int unsigned RULE_ADDR_SU = 0;
  localparam int unsigned RULE_EN_SU   = 1;
  localparam int unsigned RULE_ADDR_EN = 2;
  localparam int unsigned RULE_RETUNE  = 3;
  localparam int unsigned RULE_QUIET   = 4;
  localparam int unsigned RULE_WIDTH   = 5;

  // watched event streams feeding the age counters
  localparam int unsigned EV_SEL  = 0;
  localparam int unsigned EV_ENA  = 1;
  localparam int unsigned EV_OUT  = 2;
  localparam int unsigned EV_IN   = 3;
  localparam int unsigned N_EV    = 4;

  typedef logic [N_RULE-1:0] rule_vec_t;
endpackage

// File: rtl/dlg_since.sv
// Saturating count of samples since the last event; saturated means "no event seen".
module dlg_since #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  output logic [CW-1:0] age
);
  localparam logic [CW-1:0] SAT = '1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= SAT;
    else if (evt)        cnt <= CW'(1);
    else if (cnt != SAT) cnt <= cnt + CW'(1);
  end

  assign age = cnt;

  // an event restarts the count at one sample
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> age == CW'(1));
endmodule

// File: rtl/dlg_wait_guard.sv
// Retune wait and post-disable quiet window, plus the spurious-output window.
module dlg_wait_guard #(
  parameter int AW        = 3,
  parameter int CW        = 8,
  parameter int INC_TICKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_chg,
  input  logic [AW-1:0] sel_now,
  input  logic [AW-1:0] sel_old,
  input  logic [CW-1:0] out_dist,
  input  logic          dis_rise,
  input  logic          dis_now,
  input  logic          in_now,
  output logic          retune_hit,
  output logic          quiet_hit,
  output logic          spur_open
);
  logic [CW-1:0] need;
  logic [CW-1:0] gap;
  logic [CW-1:0] left_q, left_dec, left_d;
  logic [CW-1:0] hold_need;
  logic [CW-1:0] hold_q, hold_d;
  logic          pend_q, pend_d;

  // retune: wait only when the step count rises
  always_comb begin
    need = '0;
    if (sel_now > sel_old) need = CW'(sel_now - sel_old) * CW'(INC_TICKS);
  end

  assign retune_hit = sel_chg && (out_dist < need);
  assign gap        = need - out_dist;
  assign left_dec   = (left_q == '0) ? '0 : left_q - CW'(1);

  always_comb begin
    left_d = left_dec;
    if (retune_hit && (gap > left_dec)) left_d = gap;
  end

  // quiet window after a disable
  assign hold_need = CW'(sel_now) * CW'(INC_TICKS);

  always_comb begin
    quiet_hit = 1'b0;
    hold_d    = '0;
    if (dis_rise) begin
      quiet_hit = (hold_need != '0) && in_now;
      hold_d    = (hold_need == '0) ? '0 : hold_need - CW'(1);
    end else if (hold_q != '0) begin
      quiet_hit = !dis_now || in_now;
      hold_d    = hold_q - CW'(1);
    end
  end

  assign pend_d = (quiet_hit || pend_q) && (hold_d != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      hold_q <= '0;
      pend_q <= 1'b0;
    end else begin
      left_q <= left_d;
      hold_q <= hold_d;
      pend_q <= pend_d;
    end
  end

  assign spur_open = (left_q != '0) || pend_q;

  // the window opens only because of a violation
  assert_spur_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!spur_open && !retune_hit && !quiet_hit) |=> !spur_open);

  // lowering or keeping the select never needs a wait
  assert_lower_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_now <= sel_old) |-> !retune_hit);
endmodule

// File: rtl/dly_guard_mon.sv
module dly_guard_mon
  import dlg_pkg::*;
#(
  parameter int AW         = 3,
  parameter int INC_TICKS  = 2,
  parameter int AIS_TICKS  = 3,
  parameter int ENIS_TICKS = 3,
  parameter int AENS_TICKS = 1,
  parameter int PW_PCT     = 100,
  parameter int CW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] dl_sel,
  input  logic          dl_dis,
  input  logic          dl_in,
  input  logic          dl_out,
  output logic [5:0]    viol_flags,
  output logic          spur_open
);
  localparam int TOTAL_TICKS = ((1 << AW) - 1) * INC_TICKS;
  localparam int PW_MIN      = (TOTAL_TICKS * PW_PCT + 99) / 100;

  logic          primed;
  logic [AW-1:0] sel_q;
  logic          dis_q, in_q, out_q;
  logic          sel_chg, dis_chg, dis_rise, dis_fall, in_edge, out_edge;
  logic [N_EV-1:0] ev;
  logic [CW-1:0] age [N_EV];
  logic [CW-1:0] sel_dist, ena_dist, out_dist;
  logic          retune_hit, quiet_hit;
  rule_vec_t     hit, flags_q;

  // reference registers; the first sample after reset only primes them
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed <= 1'b0;
      sel_q  <= '0;
      dis_q  <= 1'b0;
      in_q   <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      primed <= 1'b1;
      sel_q  <= dl_sel;
      dis_q  <= dl_dis;
      in_q   <= dl_in;
      out_q  <= dl_out;
    end
  end

  assign sel_chg  = primed && (dl_sel != sel_q);
  assign dis_chg  = primed && (dl_dis != dis_q);
  assign dis_rise = dis_chg && dl_dis;
  assign dis_fall = dis_chg && !dl_dis;
  assign in_edge  = primed && (dl_in != in_q);
  assign out_edge = primed && (dl_out != out_q);

  assign ev[EV_SEL] = sel_chg;
  assign ev[EV_ENA] = dis_fall;
  assign ev[EV_OUT] = out_edge;
  assign ev[EV_IN]  = in_edge;

  for (genvar g = 0; g < N_EV; g++) begin : g_since
    dlg_since #(.CW(CW)) u_since (
      .clk  (clk),
      .rst_n(rst_n),
      .evt  (ev[g]),
      .age  (age[g])
    );
  end

  // distance from the latest event, zero when it happens in this sample
  assign sel_dist = sel_chg  ? '0 : age[EV_SEL];
  assign ena_dist = dis_fall ? '0 : age[EV_ENA];
  assign out_dist = out_edge ? '0 : age[EV_OUT];

  dlg_wait_guard #(.AW(AW), .CW(CW), .INC_TICKS(INC_TICKS)) u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_chg   (sel_chg),
    .sel_now   (dl_sel),
    .sel_old   (sel_q),
    .out_dist  (out_dist),
    .dis_rise  (dis_rise),
    .dis_now   (dl_dis),
    .in_now    (dl_in),
    .retune_hit(retune_hit),
    .quiet_hit (quiet_hit),
    .spur_open (spur_open)
  );

  always_comb begin
    hit               = '0;
    hit[RULE_ADDR_SU] = in_edge && (sel_dist < CW'(AIS_TICKS));
    hit[RULE_EN_SU]   = in_edge && (ena_dist < CW'(ENIS_TICKS));
    hit[RULE_ADDR_EN] = dis_chg && (sel_dist < CW'(AENS_TICKS));
    hit[RULE_RETUNE]  = retune_hit;
    hit[RULE_QUIET]   = quiet_hit;
    hit[RULE_WIDTH]   = in_edge && (age[EV_IN] < CW'(PW_MIN));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_q | hit;
  end

  assign viol_flags = flags_q;

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flags & $past(viol_flags)) == $past(viol_flags));

  assert_sel_setup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_edge && sel_chg && (AIS_TICKS > 0)) |=> viol_flags[RULE_ADDR_SU]);

  assert_sel_before_dis_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_chg && sel_chg && (AENS_TICKS > 0)) |=> viol_flags[RULE_ADDR_EN]);

  assert_lower_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_chg && (dl_sel < sel_q) && !viol_flags[RULE_RETUNE] && !out_edge)
      |=> !viol_flags[RULE_RETUNE]);

  assert_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_edge && $past(in_edge) && (PW_MIN > 1)) |=> viol_flags[RULE_WIDTH]);
endmodule

// File: tb/tb_dly_guard_mon.sv
`timescale 1ns/1ps
module tb_dly_guard_mon;
  localparam int AW = 3, INC = 2, AIS = 3, ENIS = 3, AENS = 1, PCT = 100;
  localparam int PWMIN = (7 * INC * PCT + 99) / 100;
  localparam int B_SU = 0, B_ENSU = 1, B_SELEN = 2, B_RET = 3, B_QUIET = 4, B_WID = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] dl_sel = '0;
  logic dl_dis = 1'b0, dl_in = 1'b0, dl_out = 1'b0;
  logic [5:0] viol_flags;
  logic spur_open;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  dly_guard_mon #(.AW(AW), .INC_TICKS(INC), .AIS_TICKS(AIS), .ENIS_TICKS(ENIS),
                  .AENS_TICKS(AENS), .PW_PCT(PCT), .CW(8)) dut (
    .clk(clk), .rst_n(rst_n), .dl_sel(dl_sel), .dl_dis(dl_dis), .dl_in(dl_in),
    .dl_out(dl_out), .viol_flags(viol_flags), .spur_open(spur_open));

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic restart(input int sel, input logic dis);
    rst_n = 1'b0; dl_sel = AW'(sel); dl_dis = dis; dl_in = 1'b0; dl_out = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  function automatic int spur_len_cnt();
    return 0;
  endfunction

  task automatic measure_spur(output int len);
    len = 0;
    while (spur_open === 1'b1 && len < 100) begin
      len++;
      step();
    end
  endtask

  initial begin
    int len, need, e;
    @(negedge clk);
    restart(0, 1'b0);
    chk("R7 reset flags", int'(viol_flags), 0);
    chk("R7 reset spur", int'(spur_open), 0);

    // R1: select change then input edge d samples later
    for (int d = 0; d <= AIS + 1; d++) begin
      restart(0, 1'b0);
      dl_sel = 3'd3; repeat (d) step(); dl_in = 1'b1; step();
      e = (d < AIS) ? (1 << B_SU) : 0;
      chk($sformatf("R1 d=%0d", d), int'(viol_flags), e);
      repeat (20) step();
      chk($sformatf("R7 sticky d=%0d", d), int'(viol_flags), e);
    end

    // R2: re-enable then input edge d samples later
    for (int d = 0; d <= ENIS + 1; d++) begin
      restart(0, 1'b1);
      dl_dis = 1'b0; repeat (d) step(); dl_in = 1'b1; step();
      chk($sformatf("R2 d=%0d", d), int'(viol_flags), (d < ENIS) ? (1 << B_ENSU) : 0);
    end

    // R3: select change then disable d samples later (window needs 2 quiet samples)
    for (int d = 0; d <= AENS + 2; d++) begin
      restart(0, 1'b0);
      dl_sel = 3'd1; repeat (d) step(); dl_dis = 1'b1; step();
      repeat (4) step();
      chk($sformatf("R3 d=%0d", d), int'(viol_flags), (d < AENS) ? (1 << B_SELEN) : 0);
    end

    // R6: pulse of width d samples
    for (int d = 1; d <= PWMIN + 1; d++) begin
      restart(0, 1'b0);
      dl_in = 1'b1; step(); repeat (d - 1) step(); dl_in = 1'b0; step();
      chk($sformatf("R6 w=%0d", d), int'(viol_flags), (d < PWMIN) ? (1 << B_WID) : 0);
    end

    // R4/R8: every old/new pair at every distance from the last output edge
    for (int o = 0; o < 8; o++) begin
      for (int n = 0; n < 8; n++) begin
        for (int d = 0; d <= 15; d++) begin
          restart(o, 1'b0);
          need = (n > o) ? (n - o) * INC : 0;
          dl_out = 1'b1; repeat (d) step(); dl_sel = AW'(n); step();
          e = (d < need) ? (1 << B_RET) : 0;
          chk($sformatf("R4 %0d->%0d d=%0d", o, n, d), int'(viol_flags), e);
          measure_spur(len);
          chk($sformatf("R8 retune %0d->%0d d=%0d", o, n, d), len, (d < need) ? need - d : 0);
        end
      end
    end

    // R5/R8: enable returns v samples after the disable
    for (int a = 0; a < 8; a++) begin
      need = a * INC;
      for (int v = 1; v <= need + 1; v++) begin
        restart(a, 1'b0);
        dl_dis = 1'b1; step(); repeat (v - 1) step(); dl_dis = 1'b0; step();
        chk($sformatf("R5 a=%0d v=%0d", a, v), int'(viol_flags), (v < need) ? (1 << B_QUIET) : 0);
        measure_spur(len);
        chk($sformatf("R8 quiet a=%0d v=%0d", a, v), len,
            (v < need && need - 1 - v > 0) ? need - 1 - v : 0);
      end
    end

    // R5: input pulse while disabled
    restart(7, 1'b0);
    dl_dis = 1'b1; step(); step(); step(); dl_in = 1'b1; step();
    chk("R5 input during quiet", int'(viol_flags), 1 << B_QUIET);
    chk("R8 quiet input spur", int'(spur_open), 1);

    // R9: a legal sequence
    restart(0, 1'b0);
    dl_sel = 3'd2; repeat (5) step();
    dl_in = 1'b1; repeat (15) step();
    dl_out = 1'b1; repeat (15) step();
    dl_in = 1'b0; repeat (15) step();
    dl_out = 1'b0; repeat (8) step();
    dl_sel = 3'd5; repeat (5) step();
    dl_sel = 3'd1; repeat (3) step();
    dl_dis = 1'b1; repeat (3) step();
    dl_dis = 1'b0; repeat (5) step();
    dl_in = 1'b1; step();
    chk("R9 clean flags", int'(viol_flags), 0);
    chk("R9 clean spur", int'(spur_open), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule